// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This block sits beside a descriptor-processing engine and decides when the engine should notify the host that work has finished. The engine supplies two inputs. One is its current count of completed descriptors that software has not yet released. The other is a one-cycle pulse for each new completion. The coalescer raises a notification in either of two cases:

- the count reaches a programmed threshold;
- an enabled idle timeout runs out while completions are still outstanding.

This lets short bursts still reach the host without one interrupt per descriptor.

The notification is a message-signalled interrupt: one write of a programmed 32-bit data word to a programmed 48-bit address. It is presented on a valid/ready handshake. The address and data are captured when the request is raised and held until it is accepted. Triggers that arrive while a request waits are merged into it. The bus write and the software handler lie outside the block.

Top module: `compl_irq_coalescer`

## Requirements
- R1: After reset `msgValid` is 0 and `msgAddr` and `msgData` are 0.
- R2: The count threshold is `thrReg[14:0]`. When it is nonzero, the count path is armed and `pendCount >= threshold`, `msgValid` is 1 after the next rising clock edge.
- R3: A count-path trigger disarms the count path. It re-arms only when `pendCount` is below the threshold, so an unchanged or growing count never raises a second request.
- R4: A count threshold of 0 disables the count path for every `pendCount`.
- R5: The timeout is enabled by `thrReg[18]`, with limit L = `tmoReg[12:0]`, L nonzero. With `pendCount` nonzero and no completion pulse, `msgValid` rises on the (L+1)th rising edge after the edge that sampled the last pulse.
- R6: Each `cmplPulse` restarts the idle timer from zero, so pulses spaced at most L edges apart never produce a timeout.
- R7: No timeout occurs when `thrReg[18]` is 0, when L is 0, or while `pendCount` is 0. The idle timer is held at zero while `pendCount` is 0.
- R8: Once `msgValid` is 1 it stays 1 until a cycle with `msgReady` at 1. It is 0 after that edge when no new trigger occurs in the accepting cycle.
- R9: Triggers that occur while a request is waiting are merged into it, so a single acceptance clears it.
- R10: When a request is raised, `msgAddr` becomes {`msgAddrHi`, `msgAddrLo`} and `msgData` becomes `msgDataCfg`. Both stay unchanged while the request waits, even if the configuration inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| thrReg | input | 32 | Count threshold [14:0], timeout enable [18] |
| tmoReg | input | 32 | Timeout limit in cycles [12:0] |
| msgAddrLo | input | 32 | Low word of the message target address |
| msgAddrHi | input | 16 | High half-word of the message target address |
| msgDataCfg | input | 32 | Message data word |
| pendCount | input | 15 | Completions awaiting release by software |
| cmplPulse | input | 1 | One-cycle pulse per new completion |
| msgReady | input | 1 | Downstream accepts the pending message |
| msgValid | output | 1 | Notification request pending |
| msgAddr | output | 48 | Captured target address |
| msgData | output | 32 | Captured data word |

## Verification
The bench sweeps count thresholds 1 to 6 and timeout limits 1 to 8, and predicts from the stated cycle rules the exact edge on which a request must appear.

- An off-by-one timer fires one edge early or one edge late against the L+1 edge prediction.
- A design that fails to disarm raises a second request while the count sits at or above the threshold.
- A design that fails to re-arm stays silent after the count drops and climbs back.
- A request that is not merged leaves `msgValid` high after a single acceptance.
- A datapath that does not capture the address and data lets them follow configuration changes while a request is pending.

// File: rtl/coal_pkg.sv
package coal_pkg;
  localparam int REG_W      = 32;
  localparam int CNT_W      = 15;
  localparam int TMR_W      = 13;
  localparam int TMR_EN_BIT = 18;
  localparam int ADDR_LO_W  = 32;
  localparam int ADDR_HI_W  = 16;
  localparam int DATA_W     = 32;

  typedef struct packed {
    logic timerClear;
    logic msgLoad;
  } coalStrobe_t;
endpackage

// File: rtl/coal_dp.sv
module coal_dp
  import coal_pkg::*;
#(
  parameter int CW  = CNT_W,
  parameter int TW  = TMR_W,
  parameter int ALW = ADDR_LO_W,
  parameter int AHW = ADDR_HI_W,
  parameter int DW  = DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  coalStrobe_t       strobe,
  input  logic              timerEn,
  input  logic [TW-1:0]     timerLimit,
  input  logic [CW-1:0]     pendCount,
  input  logic [ALW-1:0]    addrLo,
  input  logic [AHW-1:0]    addrHi,
  input  logic [DW-1:0]     dataCfg,
  output logic              timerHit,
  output logic [ALW+AHW-1:0] msgAddr,
  output logic [DW-1:0]     msgData
);
  logic [TW-1:0] timer;
  logic          timerOn;

  assign timerOn  = timerEn && (timerLimit != '0);
  assign timerHit = timerOn && (pendCount != '0) && (timer >= timerLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.timerClear || !timerOn) begin
      timer <= '0;
    end else begin
      timer <= timer + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgAddr <= '0;
      msgData <= '0;
    end else if (strobe.msgLoad) begin
      msgAddr <= {addrHi, addrLo};
      msgData <= dataCfg;
    end
  end

  // R7
  idle_timer_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == '0) |=> (timer == '0));

  // R10
  held_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.msgLoad |=> $stable(msgAddr) && $stable(msgData));
endmodule

// File: rtl/coal_ctrl.sv
module coal_ctrl
  import coal_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] pendCount,
  input  logic [CW-1:0] countThresh,
  input  logic          cmplPulse,
  input  logic          timerHit,
  input  logic          msgReady,
  output logic          msgValid,
  output coalStrobe_t   strobe
);
  logic armed;
  logic countHit;
  logic countFire;
  logic trig;
  logic accept;

  assign countHit  = (countThresh != '0) && (pendCount >= countThresh);
  assign countFire = armed && countHit;
  assign trig      = countFire || timerHit;
  assign accept    = msgValid && msgReady;

  always_comb begin
    strobe.msgLoad    = trig && (!msgValid || accept);
    strobe.timerClear = cmplPulse || (pendCount == '0) || trig;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      msgValid <= 1'b0;
    end else if (strobe.msgLoad) begin
      msgValid <= 1'b1;
    end else if (accept) begin
      msgValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b1;
    end else if (countFire) begin
      armed <= 1'b0;
    end else if (pendCount < countThresh) begin
      armed <= 1'b1;
    end
  end

  // R8
  hold_until_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid && !msgReady |=> msgValid);

  // R2
  count_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    armed && countHit |=> msgValid);

  // R5
  timeout_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerHit |=> msgValid);

  // R3
  rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    !armed && !(pendCount < countThresh) |=> !armed);
endmodule

// File: rtl/compl_irq_coalescer.sv
module compl_irq_coalescer
  import coal_pkg::*;
#(
  parameter int RW  = REG_W,
  parameter int CW  = CNT_W,
  parameter int TW  = TMR_W,
  parameter int TEB = TMR_EN_BIT,
  parameter int ALW = ADDR_LO_W,
  parameter int AHW = ADDR_HI_W,
  parameter int DW  = DATA_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [RW-1:0]      thrReg,
  input  logic [RW-1:0]      tmoReg,
  input  logic [ALW-1:0]     msgAddrLo,
  input  logic [AHW-1:0]     msgAddrHi,
  input  logic [DW-1:0]      msgDataCfg,
  input  logic [CW-1:0]      pendCount,
  input  logic               cmplPulse,
  input  logic               msgReady,
  output logic               msgValid,
  output logic [ALW+AHW-1:0] msgAddr,
  output logic [DW-1:0]      msgData
);
  coalStrobe_t   strobe;
  logic          timerHit;
  logic [CW-1:0] countThresh;
  logic          timerEn;
  logic [TW-1:0] timerLimit;
  logic          unusedCfg;

  assign countThresh = thrReg[CW-1:0];
  assign timerEn     = thrReg[TEB];
  assign timerLimit  = tmoReg[TW-1:0];
  assign unusedCfg   = ^{thrReg[RW-1:TEB+1], thrReg[TEB-1:CW], tmoReg[RW-1:TW]};

  coal_ctrl #(.CW(CW)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .pendCount  (pendCount),
    .countThresh(countThresh),
    .cmplPulse  (cmplPulse),
    .timerHit   (timerHit),
    .msgReady   (msgReady),
    .msgValid   (msgValid),
    .strobe     (strobe)
  );

  coal_dp #(.CW(CW), .TW(TW), .ALW(ALW), .AHW(AHW), .DW(DW)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .timerEn   (timerEn),
    .timerLimit(timerLimit),
    .pendCount (pendCount),
    .addrLo    (msgAddrLo),
    .addrHi    (msgAddrHi),
    .dataCfg   (msgDataCfg),
    .timerHit  (timerHit),
    .msgAddr   (msgAddr),
    .msgData   (msgData)
  );
endmodule

// File: tb/sim_compl_irq_coalescer.sv
`timescale 1ns/1ps
module sim_compl_irq_coalescer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] thrReg = '0;
  logic [31:0] tmoReg = '0;
  logic [31:0] msgAddrLo = '0;
  logic [15:0] msgAddrHi = '0;
  logic [31:0] msgDataCfg = '0;
  logic [14:0] pendCount = '0;
  logic        cmplPulse = 1'b0;
  logic        msgReady = 1'b0;
  logic        msgValid;
  logic [47:0] msgAddr;
  logic [31:0] msgData;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  compl_irq_coalescer u0 (
    .clk(clk), .rstN(rstN), .thrReg(thrReg), .tmoReg(tmoReg),
    .msgAddrLo(msgAddrLo), .msgAddrHi(msgAddrHi), .msgDataCfg(msgDataCfg),
    .pendCount(pendCount), .cmplPulse(cmplPulse), .msgReady(msgReady),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic acceptMsg();
    msgReady = 1'b1;
    step();
    msgReady = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // r1_ reset state
    chk("R1 valid", msgValid, 0);
    chk("R1 addr", msgAddr, 0);
    chk("R1 data", msgData, 0);
    rstN = 1'b1;
    step();

    // Count threshold sweep
    for (int t = 1; t <= 6; t++) begin
      thrReg = 32'(t);
      tmoReg = '0;
      msgAddrLo = 32'hA000_0000 + 32'(t);
      msgAddrHi = 16'h0B00 + 16'(t);
      msgDataCfg = 32'hD000_0000 + 32'(t);
      pendCount = '0;
      step();
      for (int p = 1; p <= t + 1; p++) begin
        pendCount = 15'(p);
        step();
        chk("R2 count raise", msgValid, (p >= t) ? 1 : 0);
      end
      chk("R10 addr", msgAddr, {16'h0B00 + 16'(t), 32'hA000_0000 + 32'(t)});
      chk("R10 data", msgData, 32'hD000_0000 + 32'(t));
      msgAddrLo = 32'h1234_5678;
      msgDataCfg = 32'h5555_AAAA;
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R8 hold", msgValid, 1);
      end
      chk("R10 addr stable", msgAddr, {16'h0B00 + 16'(t), 32'hA000_0000 + 32'(t)});
      chk("R10 data stable", msgData, 32'hD000_0000 + 32'(t));
      acceptMsg();
      chk("R8 accept", msgValid, 0);
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R3 no refire", msgValid, 0);
      end
      pendCount = 15'(t - 1);
      step();
      chk("R3 below", msgValid, 0);
      pendCount = 15'(t);
      step();
      chk("R3 rearm", msgValid, 1);
      chk("R10 new data", msgData, 32'h5555_AAAA);
      acceptMsg();
      pendCount = '0;
      step();
    end

    // R4 zero threshold
    thrReg = 32'd0;
    for (int p = 1; p <= 20; p++) begin
      pendCount = 15'(p);
      step();
      chk("R4 zero thresh", msgValid, 0);
    end
    pendCount = '0;
    step();

    // R9 merge
    thrReg = 32'd3;
    pendCount = 15'd3;
    step();
    chk("R9 first", msgValid, 1);
    pendCount = '0;
    step();
    pendCount = 15'd3;
    step();
    chk("R9 still one", msgValid, 1);
    acceptMsg();
    chk("R9 single accept", msgValid, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R9 no second", msgValid, 0);
    end
    pendCount = '0;
    step();

    // R5 timeout sweep
    for (int l = 1; l <= 8; l++) begin
      thrReg = (32'd1 << 18) | 32'd100;
      tmoReg = 32'(l);
      pendCount = '0;
      step();
      pendCount = 15'd3;
      cmplPulse = 1'b1;
      step();
      cmplPulse = 1'b0;
      for (int k = 1; k <= l; k++) begin
        step();
        chk("R5 before expiry", msgValid, 0);
      end
      step();
      chk("R5 expiry", msgValid, 1);
      acceptMsg();
      chk("R8 accept timeout", msgValid, 0);
      pendCount = '0;
      step();
    end

    // R6 restart on pulse
    tmoReg = 32'd4;
    pendCount = 15'd2;
    for (int n = 0; n < 5; n++) begin
      cmplPulse = 1'b1;
      step();
      cmplPulse = 1'b0;
      for (int k = 0; k < 3; k++) begin
        step();
        chk("R6 restart", msgValid, 0);
      end
    end
    cmplPulse = 1'b1;
    step();
    cmplPulse = 1'b0;
    for (int k = 1; k <= 4; k++) step();
    chk("R6 quiet", msgValid, 0);
    step();
    chk("R6 expiry", msgValid, 1);
    acceptMsg();
    pendCount = '0;
    step();

    // R7 suppressed timeouts
    thrReg = 32'd100;
    tmoReg = 32'd3;
    pendCount = 15'd5;
    for (int k = 0; k < 20; k++) step();
    chk("R7 disabled", msgValid, 0);
    thrReg = (32'd1 << 18) | 32'd100;
    tmoReg = 32'd0;
    for (int k = 0; k < 20; k++) step();
    chk("R7 zero limit", msgValid, 0);
    tmoReg = 32'd3;
    pendCount = '0;
    for (int k = 0; k < 20; k++) step();
    chk("R7 zero pending", msgValid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule